// File: doc/BRIEF.md
# Candidate State Keystream Checker

This block decides whether one guessed internal state of a three-register, majority-clocked stream generator produces a given known keystream. A guessing engine hands it a complete 64-bit state split across the three shift registers (19, 22 and 23 bits) and 64 known keystream bits. It then pulses start. The block loads the registers as they stand after warm-up, with no key or IV setup, and runs the generator with stop/go clocking. After each step it compares the generated bit with the next known bit.

Checking ends at the first disagreement, which rejects the candidate. If all 64 bits agree, the candidate is accepted. The verdict is a match flag or a reject flag, plus the number of bits that agreed before the stop. Both stay on the ports until the next accepted start. A new candidate may be started in the cycle right after a verdict, so a queue of candidates can be streamed through with no idle gap.

Top module: `ks_candidate_checker`

## Requirements
- R1: After reset, busy, match and reject are 0 and the agreement count is 0.
- R2: A start pulse while idle loads the three registers from the candidate inputs, latches the keystream word, clears both flags and the count, and raises busy on the following cycle.
- R3: In each check step, bit 8 of register A, bit 10 of register B and bit 10 of register C vote. Only registers whose voting bit equals the majority shift, so at least two registers step. A register steps by shifting toward its MSB, and the XOR of its tap bits enters bit 0. The taps are A: 18,17,16,13; B: 21,20; C: 22,21,20,7.
- R4: The output bit of step i+1 is the XOR of A[18], B[21] and C[22] after that step. It is compared with keystream input bit i, where bit 0 of the word is used first.
- R5: On the first disagreement, reject is set, busy falls, and the count equals the number of earlier bits that agreed.
- R6: When all 64 bits agree, match is set, the count reads 64, and busy falls.
- R7: Busy stays high for exactly k+1 cycles when the first mismatch is at bit k, and for 64 cycles on a full match. A verdict therefore appears at most 65 cycles after start is sampled.
- R8: A start pulse while busy is ignored. The running check completes with the verdict of the candidate loaded first.
- R9: Match and reject are never both set. While idle and without start, the flags and the count are held stable.
- R10: A start given in the cycle after a verdict is accepted, so candidates run back-to-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin checking the presented candidate |
| cand_a_i | input | 19 | Candidate content of register A |
| cand_b_i | input | 22 | Candidate content of register B |
| cand_c_i | input | 23 | Candidate content of register C |
| ks_i | input | 64 | Known keystream, bit 0 compared first |
| busy_o | output | 1 | Check in progress |
| match_o | output | 1 | Candidate accepted (all bits agreed) |
| reject_o | output | 1 | Candidate rejected at first mismatch |
| agree_o | output | 7 | Bits that agreed before the stop (0 to 64) |

## Verification
A random candidate against a random keystream almost always fails within the first few bits, so late mismatches and full matches would essentially never occur by chance. The bench therefore derives the exact 64-bit stream of each random candidate with its own model of the generator. It uses that stream unchanged to force full matches, and flips a single chosen bit to place the first mismatch at any index, including 0 and 63. The same derived streams are used to show that a start given mid-run is ignored, and to run candidates back-to-back.

// File: rtl/ks_cc_pkg.sv
package ks_cc_pkg;
   localparam int unsigned REG_A_LEN = 19;
   localparam int unsigned REG_B_LEN = 22;
   localparam int unsigned REG_C_LEN = 23;
   localparam int unsigned VOTE_A    = 8;
   localparam int unsigned VOTE_B    = 10;
   localparam int unsigned VOTE_C    = 10;
   // feedback tap masks, bit n set means register bit n feeds the XOR
   localparam logic [REG_A_LEN-1:0] TAPS_A = 19'h72000;
   localparam logic [REG_B_LEN-1:0] TAPS_B = 22'h300000;
   localparam logic [REG_C_LEN-1:0] TAPS_C = 23'h700080;

   typedef enum logic [1:0] {
      CC_IDLE_NONE = 2'b00,
      CC_IDLE_PASS = 2'b01,
      CC_IDLE_FAIL = 2'b10
   } cc_verdict_e;
endpackage

// File: rtl/cc_stopgo_reg.sv
module cc_stopgo_reg #(
   parameter int unsigned LEN     = 19,
   parameter int unsigned VOTE    = 8,
   parameter logic [LEN-1:0] TAPS = '1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load_i,
   input  logic [LEN-1:0] load_val_i,
   input  logic           step_i,
   output logic           vote_o,
   output logic           next_msb_o
);
   logic [LEN-1:0] r_q;
   logic           fb;

   if (LEN < 2) begin : g_bad_len
      $error("cc_stopgo_reg: LEN must be at least 2");
   end
   if (VOTE >= LEN) begin : g_bad_vote
      $error("cc_stopgo_reg: VOTE must lie inside the register");
   end
   if (TAPS[LEN-1] != 1'b1) begin : g_bad_taps
      $error("cc_stopgo_reg: the MSB must be a feedback tap");
   end

   assign fb         = ^(r_q & TAPS);
   assign vote_o     = r_q[VOTE];
   // the MSB that appears once this cycle's step (if any) is taken
   assign next_msb_o = step_i ? r_q[LEN-2] : r_q[LEN-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      r_q <= '0;
      else if (load_i) r_q <= load_val_i;
      else if (step_i) r_q <= {r_q[LEN-2:0], fb};
   end

   // a load and a step never coincide
   assert_load_no_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_i && step_i));
endmodule

// File: rtl/cc_majority.sv
module cc_majority #(
   parameter int unsigned N = 3
) (
   input  logic [N-1:0] vote_i,
   input  logic         enable_i,
   output logic [N-1:0] step_o
);
   logic maj;

   if (N != 3) begin : g_bad_n
      $error("cc_majority: exactly three voters are supported");
   end

   assign maj = (vote_i[0] & vote_i[1]) | (vote_i[0] & vote_i[2]) |
                (vote_i[1] & vote_i[2]);

   for (genvar g = 0; g < N; g++) begin : g_step
      assign step_o[g] = enable_i & (vote_i[g] == maj);
   end
endmodule

// File: rtl/ks_candidate_checker.sv
module ks_candidate_checker
   import ks_cc_pkg::*;
#(
   parameter int unsigned KS_LEN = 64,
   parameter int unsigned CNT_W  = $clog2(KS_LEN + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [REG_A_LEN-1:0] cand_a_i,
   input  logic [REG_B_LEN-1:0] cand_b_i,
   input  logic [REG_C_LEN-1:0] cand_c_i,
   input  logic [KS_LEN-1:0]    ks_i,
   output logic                 busy_o,
   output logic                 match_o,
   output logic                 reject_o,
   output logic [CNT_W-1:0]     agree_o
);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(KS_LEN - 1);

   if (KS_LEN < 1) begin : g_bad_ks
      $error("ks_candidate_checker: KS_LEN must be positive");
   end
   if ((1 << CNT_W) <= KS_LEN) begin : g_bad_cnt
      $error("ks_candidate_checker: CNT_W too narrow for KS_LEN");
   end

   logic              busy_q;
   cc_verdict_e       verdict_q;
   logic [CNT_W-1:0]  agree_q;
   logic [KS_LEN-1:0] ks_q;
   logic              load;
   logic [2:0]        votes, steps, msbs;
   logic              gen_bit, hit;

   assign load = start_i && !busy_q;

   cc_stopgo_reg #(.LEN(REG_A_LEN), .VOTE(VOTE_A), .TAPS(TAPS_A)) u_reg_a (
      .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(cand_a_i),
      .step_i(steps[0]), .vote_o(votes[0]), .next_msb_o(msbs[0]));
   cc_stopgo_reg #(.LEN(REG_B_LEN), .VOTE(VOTE_B), .TAPS(TAPS_B)) u_reg_b (
      .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(cand_b_i),
      .step_i(steps[1]), .vote_o(votes[1]), .next_msb_o(msbs[1]));
   cc_stopgo_reg #(.LEN(REG_C_LEN), .VOTE(VOTE_C), .TAPS(TAPS_C)) u_reg_c (
      .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(cand_c_i),
      .step_i(steps[2]), .vote_o(votes[2]), .next_msb_o(msbs[2]));

   cc_majority #(.N(3)) u_vote (
      .vote_i(votes), .enable_i(busy_q), .step_o(steps));

   assign gen_bit = ^msbs;
   assign hit     = (gen_bit == ks_q[0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         verdict_q <= CC_IDLE_NONE;
         agree_q   <= '0;
         ks_q      <= '0;
      end else if (load) begin
         busy_q    <= 1'b1;
         verdict_q <= CC_IDLE_NONE;
         agree_q   <= '0;
         ks_q      <= ks_i;
      end else if (busy_q) begin
         ks_q <= ks_q >> 1;
         if (!hit) begin
            busy_q    <= 1'b0;
            verdict_q <= CC_IDLE_FAIL;
         end else begin
            agree_q <= agree_q + CNT_W'(1);
            if (agree_q == LAST_IDX) begin
               busy_q    <= 1'b0;
               verdict_q <= CC_IDLE_PASS;
            end
         end
      end
   end

   assign busy_o   = busy_q;
   assign match_o  = (verdict_q == CC_IDLE_PASS);
   assign reject_o = (verdict_q == CC_IDLE_FAIL);
   assign agree_o  = agree_q;

   assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !match_o && !reject_o) |-> (agree_o == '0));
   assert_start_raises_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && !match_o && !reject_o && agree_o == '0));
   assert_two_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> ($countones(steps) >= 2));
   assert_idle_no_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (steps == 3'b000));
   assert_full_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      match_o |-> (agree_o == CNT_W'(KS_LEN)));
   assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (agree_o < CNT_W'(KS_LEN)));
   assert_fall_has_verdict_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (match_o ^ reject_o));
   assert_busy_ignores_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> (agree_o != '0 || !busy_o));
   assert_one_verdict_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(match_o && reject_o));
   assert_verdict_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> ($stable(match_o) && $stable(reject_o) && $stable(agree_o)));
endmodule

// File: tb/ks_candidate_checker_test.sv
module ks_candidate_checker_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [18:0] cand_a_i = '0;
   logic [21:0] cand_b_i = '0;
   logic [22:0] cand_c_i = '0;
   logic [63:0] ks_i = '0;
   logic        busy_o, match_o, reject_o;
   logic [6:0]  agree_o;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;   // 8 ns period

   ks_candidate_checker uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .cand_a_i(cand_a_i), .cand_b_i(cand_b_i), .cand_c_i(cand_c_i),
      .ks_i(ks_i), .busy_o(busy_o), .match_o(match_o), .reject_o(reject_o),
      .agree_o(agree_o));

   task automatic check(input string req, input logic [63:0] act,
                        input logic [63:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // reference generator written from the requirements: 64 output bits
   function automatic logic [63:0] model_stream(input logic [18:0] a0,
         input logic [21:0] b0, input logic [22:0] c0);
      logic [18:0] a = a0;
      logic [21:0] b = b0;
      logic [22:0] c = c0;
      logic [63:0] s = '0;
      for (int i = 0; i < 64; i++) begin
         logic m;
         m = (a[8] + b[10] + c[10]) >= 2;
         if (a[8] == m)  a = {a[17:0], a[18] ^ a[17] ^ a[16] ^ a[13]};
         if (b[10] == m) b = {b[20:0], b[21] ^ b[20]};
         if (c[10] == m) c = {c[21:0], c[22] ^ c[21] ^ c[20] ^ c[7]};
         s[i] = a[18] ^ b[21] ^ c[22];
      end
      return s;
   endfunction

   function automatic int leading_agree(input logic [63:0] s, input logic [63:0] k);
      for (int i = 0; i < 64; i++) if (s[i] != k[i]) return i;
      return 64;
   endfunction

   // runs one candidate; inputs driven and outputs sampled on falling edges
   task automatic run_one(input logic [18:0] a, input logic [21:0] b,
                          input logic [22:0] c, input logic [63:0] k,
                          input string req);
      int exp_n, busy_cycles;
      exp_n = leading_agree(model_stream(a, b, c), k);
      cand_a_i = a; cand_b_i = b; cand_c_i = c; ks_i = k; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check("R2", {63'd0, busy_o}, 64'd1, "busy after start");
      busy_cycles = 0;
      while (busy_o) begin
         busy_cycles++;
         @(negedge clk);
      end
      check(req, {57'd0, agree_o}, 64'(exp_n), "agree count");
      check(req, {62'd0, match_o, reject_o},
            (exp_n == 64) ? 64'd2 : 64'd1, "match/reject flags");
      check("R7", 64'(busy_cycles), (exp_n == 64) ? 64'd64 : 64'(exp_n + 1),
            "busy length");
   endtask

   initial begin
      void'($urandom(32'd1357));
      #1000000;
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog run did not complete actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [18:0] a;
      logic [21:0] b;
      logic [22:0] c;
      logic [63:0] s;
      repeat (3) @(negedge clk);
      check("R1", {60'd0, busy_o, match_o, reject_o, 1'b0}, 64'd0, "flags after reset");
      check("R1", {57'd0, agree_o}, 64'd0, "count after reset");
      rst_n = 1'b1;
      @(negedge clk);

      // R6: all-zero state yields a constant-zero stream -> full match
      run_one('0, '0, '0, 64'd0, "R6");
      // R5: same state, mismatch at bit 0
      run_one('0, '0, '0, 64'd1, "R5");

      // R3/R4/R6: full matches on random states, run back-to-back (R10)
      for (int t = 0; t < 6; t++) begin
         a = 19'($urandom()); b = 22'($urandom()); c = 23'($urandom());
         run_one(a, b, c, model_stream(a, b, c), "R10");
      end
      // R5: forced first mismatch at chosen indices including 63
      foreach (s[i]) begin end
      for (int k = 0; k < 64; k += 9) begin
         a = 19'($urandom()); b = 22'($urandom()); c = 23'($urandom());
         s = model_stream(a, b, c);
         s[k] = ~s[k];
         run_one(a, b, c, s, "R5");
      end
      a = 19'($urandom()); b = 22'($urandom()); c = 23'($urandom());
      s = model_stream(a, b, c);
      s[63] = ~s[63];
      run_one(a, b, c, s, "R5");
      // R4: random keystreams against random states
      for (int t = 0; t < 20; t++) begin
         run_one(19'($urandom()), 22'($urandom()), 23'($urandom()),
                 {$urandom(), $urandom()}, "R4");
      end

      // R9: verdict held while idle
      repeat (5) @(negedge clk);
      check("R9", {62'd0, match_o, reject_o}, 64'd1, "flags held idle");

      // R8: start while busy is ignored
      a = 19'($urandom()); b = 22'($urandom()); c = 23'($urandom());
      s = model_stream(a, b, c);
      cand_a_i = a; cand_b_i = b; cand_c_i = c; ks_i = s; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (10) @(negedge clk);
      cand_a_i = ~a; ks_i = ~s; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      while (busy_o) @(negedge clk);
      check("R8", {62'd0, match_o, reject_o}, 64'd2, "first candidate verdict kept");
      check("R8", {57'd0, agree_o}, 64'd64, "first candidate count kept");

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule